// File: doc/BRIEF.md
# Configurable Multiply-Accumulate Slice

This block is a pipelined arithmetic slice with four multipliers. Each takes an A operand and a B operand. A two-bit mode input, sampled with each operand set, selects how the products are combined. The slice can return one product on its own. It can add a product into, or take it out of, a running accumulator. It can also return the sum or difference of two products, or the sum or difference of two pairs of products. Signedness of the A operands and of the B operands, the add/subtract choice and the accumulator clear are all run-time inputs that travel down the pipeline with their sample.

The A operand registers can be turned into a shift line. A serial sample stream enters lane 0 and moves one lane further on each accepted sample, so one stream feeds all four multipliers, as in a FIR tap line. Three register stages can each be removed by parameter: the operand stage, the product stage and the result stage. Latency in cycles equals the number of stages that are kept, and the output-valid flag follows the same delay.

Top module: `mac_slice`

## Requirements
- R1: While reset is asserted and after its release, until a sample emerges, `out_valid` is 0. With the result stage present, `result` is 0 in that period.
- R2: Every sample accepted with `in_valid`=1 yields exactly one `out_valid` pulse, in order. The pulse comes IN_REG+MUL_REG+OUT_REG cycles later, which is 3 with the defaults.
- R3: Mode 0 (single) gives `result` = A0*B0, sign-extended to the result width.
- R4: Mode 1 (accumulate) sets acc = acc + A0*B0, or acc − A0*B0 when `sub`=1. `result` shows the new acc.
- R5: In mode 1 with `acc_clr`=1, the previous accumulator value is replaced by zero. `result` is then ±A0*B0.
- R6: The accumulator keeps its value through samples in modes 0, 2 and 3, and through cycles with `in_valid`=0 whatever the other inputs are.
- R7: Mode 2 gives A0*B0 + A1*B1, or A0*B0 − A1*B1 when `sub`=1.
- R8: Mode 3 gives (A0*B0 + A1*B1) + (A2*B2 + A3*B3), or the first pair minus the second pair when `sub`=1.
- R9: `a_signed`=1 treats every A operand as two's complement, and 0 treats it as unsigned. `b_signed` does the same for the B operands. A product of two unsigned operands is never negative.
- R10: With `shift_en`=1 on an accepted sample, multiplier i>0 takes as its A operand the A operand that multiplier i−1 held before this sample, and lane 0 takes `a_in` lane 0. The A lanes 1 to 3 of `a_in` are then ignored. The line advances only on accepted samples.
- R11: `sub`, `mode`, and both sign controls may change on every sample. Each sample uses its own values.
- R12: The accumulator is PW+GUARD bits wide, with PW = AW+BW+1 (45 bits by default), and wraps modulo 2^45.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand set and controls are accepted this cycle |
| mode | input | 2 | 0 single, 1 accumulate, 2 two-product sum, 3 four-product sum |
| sub | input | 1 | Selects subtraction in modes 1 to 3 |
| acc_clr | input | 1 | In mode 1, replaces the accumulator feedback with zero |
| a_signed | input | 1 | A operands are two's complement |
| b_signed | input | 1 | B operands are two's complement |
| shift_en | input | 1 | A operands shift lane to lane |
| a_in | input | 4*AW | A operands, lane i at bits [i*AW +: AW] |
| b_in | input | 4*BW | B operands, lane i at bits [i*BW +: BW] |
| out_valid | output | 1 | `result` holds a finished sample |
| result | output | AW+BW+1+GUARD | Sum, product or accumulator value |

## Verification
The bench goes after the accumulator's state across mode changes and idle cycles. A design that let a two-product sample or an idle cycle with `acc_clr` touch the accumulator would then give a wrong total on the next accumulate sample. It drives extreme operands under every signedness mix, where a missing or doubled sign extension turns the all-ones unsigned square negative. It runs a long run of maximal unsigned adds, so a narrow accumulator wraps at the wrong modulus. It also streams samples through the shift line, where a lane that takes its neighbour's new value instead of its old one, or that shifts on idle cycles, breaks the expected tap products. The latency of every result is checked, which catches a stage that is kept or dropped against its parameter.

// File: rtl/mac_pkg.sv
package mac_pkg;

  localparam int NUM_MULT = 4;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_MACC   = 2'd1,
    MODE_SUM2   = 2'd2,
    MODE_SUM4   = 2'd3
  } mac_mode_e;

  typedef struct packed {
    logic      valid;
    mac_mode_e mode;
    logic      sub;
    logic      clr;
  } mac_ctrl_t;

endpackage

// File: rtl/mac_operand_stage.sv
module mac_operand_stage
  import mac_pkg::*;
#(
  parameter int AW     = 18,
  parameter int BW     = 18,
  parameter int LANES  = 4,
  parameter bit IN_REG = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                shift_en,
  input  logic [LANES*AW-1:0] a_in,
  input  logic [LANES*BW-1:0] b_in,
  input  logic [1:0]          sgn_in,
  input  mac_ctrl_t           ctrl_in,
  output logic [LANES*AW-1:0] a_out,
  output logic [LANES*BW-1:0] b_out,
  output logic [1:0]          sgn_out,
  output mac_ctrl_t           ctrl_out
);

  // tap_q always exists: it carries the shift line even without an operand stage
  logic [LANES*AW-1:0] tap_q;
  logic [LANES*AW-1:0] tap_sel;
  logic                tap_advance;

  assign tap_advance = in_valid;

  always_comb begin
    tap_sel[AW-1:0] = a_in[AW-1:0];
    for (int i = 1; i < LANES; i++) begin
      tap_sel[i*AW +: AW] = shift_en ? tap_q[(i-1)*AW +: AW] : a_in[i*AW +: AW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           tap_q <= '0;
    else if (tap_advance) tap_q <= tap_sel;
  end

  generate
    if (IN_REG) begin : g_in_reg
      logic [LANES*BW-1:0] b_q;
      logic [1:0]          sgn_q;
      mac_ctrl_t           ctrl_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          b_q    <= '0;
          sgn_q  <= '0;
          ctrl_q <= '0;
        end else begin
          ctrl_q <= ctrl_in;
          if (in_valid) begin
            b_q   <= b_in;
            sgn_q <= sgn_in;
          end
        end
      end
      assign a_out    = tap_q;
      assign b_out    = b_q;
      assign sgn_out  = sgn_q;
      assign ctrl_out = ctrl_q;
    end else begin : g_in_comb
      assign a_out    = tap_sel;
      assign b_out    = b_in;
      assign sgn_out  = sgn_in;
      assign ctrl_out = ctrl_in;
    end
  endgenerate

  generate
    if (LANES > 1) begin : g_shift_chk
      AST_SHIFT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && shift_en) |=> (tap_q[AW +: AW] == $past(tap_q[AW-1:0]))); // R10
    end
  endgenerate

  AST_TAP_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(tap_q)); // R10

endmodule

// File: rtl/mac_mult_stage.sv
module mac_mult_stage
  import mac_pkg::*;
#(
  parameter int AW      = 18,
  parameter int BW      = 18,
  parameter int LANES   = 4,
  parameter bit MUL_REG = 1'b1,
  localparam int PW     = AW + BW + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LANES*AW-1:0] a_in,
  input  logic [LANES*BW-1:0] b_in,
  input  logic [1:0]          sgn_in,
  input  mac_ctrl_t           ctrl_in,
  output logic [LANES*PW-1:0] prod_out,
  output mac_ctrl_t           ctrl_out
);

  // one extra bit per operand holds the sign (or a zero for unsigned)
  function automatic logic [PW-1:0] mul_one(logic [AW-1:0] a, logic [BW-1:0] b,
                                            logic a_s, logic b_s);
    logic signed [AW:0]   ea;
    logic signed [BW:0]   eb;
    logic signed [PW-1:0] wa;
    logic signed [PW-1:0] wb;
    ea = {a_s & a[AW-1], a};
    eb = {b_s & b[BW-1], b};
    wa = PW'(ea);
    wb = PW'(eb);
    return wa * wb;
  endfunction

  logic [LANES*PW-1:0] prod_comb;
  logic                both_unsigned;

  assign both_unsigned = ctrl_in.valid && (sgn_in == 2'b00);

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign prod_comb[i*PW +: PW] = mul_one(a_in[i*AW +: AW], b_in[i*BW +: BW],
                                             sgn_in[1], sgn_in[0]);
    end
  endgenerate

  generate
    if (MUL_REG) begin : g_mul_reg
      logic [LANES*PW-1:0] prod_q;
      mac_ctrl_t           ctrl_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          prod_q <= '0;
          ctrl_q <= '0;
        end else begin
          ctrl_q <= ctrl_in;
          if (ctrl_in.valid) prod_q <= prod_comb;
        end
      end
      assign prod_out = prod_q;
      assign ctrl_out = ctrl_q;
    end else begin : g_mul_comb
      assign prod_out = prod_comb;
      assign ctrl_out = ctrl_in;
    end
  endgenerate

  AST_UNSIGNED_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    both_unsigned |-> !prod_comb[PW-1]); // R9

endmodule

// File: rtl/mac_combine.sv
module mac_combine
  import mac_pkg::*;
#(
  parameter int PW      = 37,
  parameter int RW      = 45,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_MULT*PW-1:0] prod_in,
  input  mac_ctrl_t              ctrl_in,
  output logic [RW-1:0]          result,
  output logic                   out_valid
);

  function automatic logic [RW-1:0] widen(logic [PW-1:0] p);
    return RW'($signed(p));
  endfunction

  function automatic logic [RW-1:0] add_sub(logic [RW-1:0] x, logic [RW-1:0] y, logic s);
    return s ? (x - y) : (x + y);
  endfunction

  logic [RW-1:0] acc_q;
  logic [RW-1:0] acc_base;
  logic [RW-1:0] w0, w1, w2, w3;
  logic [RW-1:0] pair_lo, pair_hi;
  logic [RW-1:0] sum;
  logic          acc_we;

  assign w0 = widen(prod_in[0*PW +: PW]);
  assign w1 = widen(prod_in[1*PW +: PW]);
  assign w2 = widen(prod_in[2*PW +: PW]);
  assign w3 = widen(prod_in[3*PW +: PW]);

  assign pair_lo  = w0 + w1;
  assign pair_hi  = w2 + w3;
  assign acc_base = ctrl_in.clr ? '0 : acc_q;
  assign acc_we   = ctrl_in.valid && (ctrl_in.mode == MODE_MACC);

  always_comb begin
    unique case (ctrl_in.mode)
      MODE_SINGLE: sum = w0;
      MODE_MACC:   sum = add_sub(acc_base, w0, ctrl_in.sub);
      MODE_SUM2:   sum = add_sub(w0, w1, ctrl_in.sub);
      MODE_SUM4:   sum = add_sub(pair_lo, pair_hi, ctrl_in.sub);
      default:     sum = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_we) acc_q <= sum;
  end

  generate
    if (OUT_REG) begin : g_out_reg
      logic [RW-1:0] res_q;
      logic          vld_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          res_q <= '0;
          vld_q <= 1'b0;
        end else begin
          vld_q <= ctrl_in.valid;
          if (ctrl_in.valid) res_q <= sum;
        end
      end
      assign result    = res_q;
      assign out_valid = vld_q;
    end else begin : g_out_comb
      assign result    = sum;
      assign out_valid = ctrl_in.valid;
    end
  endgenerate

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_we |=> $stable(acc_q)); // R6

  AST_ACC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_we && ctrl_in.clr && !ctrl_in.sub) |=> (acc_q == $past(w0))); // R5

endmodule

// File: rtl/mac_slice.sv
module mac_slice
  import mac_pkg::*;
#(
  parameter int AW       = 18,
  parameter int BW       = 18,
  parameter int GUARD    = 8,
  parameter bit IN_REG   = 1'b1,
  parameter bit MUL_REG  = 1'b1,
  parameter bit OUT_REG  = 1'b1,
  localparam int PW      = AW + BW + 1,
  localparam int RW      = PW + GUARD
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [1:0]             mode,
  input  logic                   sub,
  input  logic                   acc_clr,
  input  logic                   a_signed,
  input  logic                   b_signed,
  input  logic                   shift_en,
  input  logic [NUM_MULT*AW-1:0] a_in,
  input  logic [NUM_MULT*BW-1:0] b_in,
  output logic                   out_valid,
  output logic [RW-1:0]          result
);

  mac_ctrl_t              ctrl_s0, ctrl_s1, ctrl_s2;
  logic [NUM_MULT*AW-1:0] a_s1;
  logic [NUM_MULT*BW-1:0] b_s1;
  logic [1:0]             sgn_s1;
  logic [NUM_MULT*PW-1:0] prod_s2;

  assign ctrl_s0.valid = in_valid;
  assign ctrl_s0.mode  = mac_mode_e'(mode);
  assign ctrl_s0.sub   = sub;
  assign ctrl_s0.clr   = acc_clr;

  mac_operand_stage #(
    .AW(AW), .BW(BW), .LANES(NUM_MULT), .IN_REG(IN_REG)
  ) i_operand (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .shift_en (shift_en),
    .a_in     (a_in),
    .b_in     (b_in),
    .sgn_in   ({a_signed, b_signed}),
    .ctrl_in  (ctrl_s0),
    .a_out    (a_s1),
    .b_out    (b_s1),
    .sgn_out  (sgn_s1),
    .ctrl_out (ctrl_s1)
  );

  mac_mult_stage #(
    .AW(AW), .BW(BW), .LANES(NUM_MULT), .MUL_REG(MUL_REG)
  ) i_mult (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_in     (a_s1),
    .b_in     (b_s1),
    .sgn_in   (sgn_s1),
    .ctrl_in  (ctrl_s1),
    .prod_out (prod_s2),
    .ctrl_out (ctrl_s2)
  );

  mac_combine #(
    .PW(PW), .RW(RW), .OUT_REG(OUT_REG)
  ) i_combine (
    .clk       (clk),
    .rst_n     (rst_n),
    .prod_in   (prod_s2),
    .ctrl_in   (ctrl_s2),
    .result    (result),
    .out_valid (out_valid)
  );

  AST_NO_VALID_IN_RESET: assert property (@(posedge clk)
    !rst_n |=> !out_valid); // R1

endmodule

// File: tb/test_mac_slice.sv
module test_mac_slice;

  localparam int AW  = 18;
  localparam int BW  = 18;
  localparam int PW  = AW + BW + 1;
  localparam int RW  = PW + 8;
  localparam int LAT = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic [1:0]        mode = '0;
  logic              sub = 1'b0;
  logic              acc_clr = 1'b0;
  logic              a_signed = 1'b0;
  logic              b_signed = 1'b0;
  logic              shift_en = 1'b0;
  logic [4*AW-1:0]   a_in = '0;
  logic [4*BW-1:0]   b_in = '0;
  logic              out_valid;
  logic [RW-1:0]     result;

  mac_slice i_mac_slice (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .sub(sub),
    .acc_clr(acc_clr), .a_signed(a_signed), .b_signed(b_signed),
    .shift_en(shift_en), .a_in(a_in), .b_in(b_in),
    .out_valid(out_valid), .result(result)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  logic [RW-1:0] q_exp[$];
  int            q_cyc[$];
  string         q_tag[$];

  longint          m_acc = 0;
  logic [AW-1:0]   m_tap [4];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint ext_a(logic [AW-1:0] x, logic s);
    return s ? longint'($signed(x)) : longint'(x);
  endfunction
  function automatic longint ext_b(logic [BW-1:0] x, logic s);
    return s ? longint'($signed(x)) : longint'(x);
  endfunction

  task automatic check(bit ok, string tag, logic [RW-1:0] act, logic [RW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one accepted sample, expected value queued
  task automatic drive(input logic [1:0] md, input bit sb, input bit cl,
                       input bit as, input bit bs, input bit sh,
                       input logic [4*AW-1:0] av, input logic [4*BW-1:0] bv,
                       input string tag);
    longint p [4];
    longint r;
    longint base;
    logic [AW-1:0] nt [4];
    @(negedge clk);
    in_valid = 1'b1; mode = md; sub = sb; acc_clr = cl;
    a_signed = as; b_signed = bs; shift_en = sh; a_in = av; b_in = bv;
    nt[0] = av[AW-1:0];
    for (int i = 1; i < 4; i++) nt[i] = sh ? m_tap[i-1] : av[i*AW +: AW];
    for (int i = 0; i < 4; i++) begin
      m_tap[i] = nt[i];
      p[i] = ext_a(nt[i], as) * ext_b(bv[i*BW +: BW], bs);
    end
    case (md)
      2'd0: r = p[0];
      2'd1: begin
        base  = cl ? 0 : m_acc;
        m_acc = sb ? base - p[0] : base + p[0];
        r     = m_acc;
      end
      2'd2: r = sb ? p[0] - p[1] : p[0] + p[1];
      default: r = sb ? (p[0] + p[1]) - (p[2] + p[3]) : (p[0] + p[1]) + (p[2] + p[3]);
    endcase
    q_exp.push_back(r[RW-1:0]);
    q_cyc.push_back(cyc);
    q_tag.push_back(tag);
  endtask

  // idle cycle with junk controls that must not matter
  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0; mode = 2'd1; acc_clr = 1'b1; sub = $urandom_range(1);
      shift_en = 1'b1;
      a_in = {$urandom, $urandom, $urandom};
      b_in = {$urandom, $urandom, $urandom};
    end
  endtask

  function automatic logic [4*AW-1:0] rnd_a();
    return {$urandom, $urandom, $urandom};
  endfunction

  // monitor: pops expected items as results appear
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_exp.size() == 0) begin
        check(1'b0, "R2 unexpected out_valid", result, '0);
      end else begin
        logic [RW-1:0] e;
        int            c;
        string         t;
        e = q_exp.pop_front();
        c = q_cyc.pop_front();
        t = q_tag.pop_front();
        check((cyc - c) == LAT, "R2 latency", RW'(cyc - c), RW'(LAT));
        check(result == e, t, result, e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R2 watchdog: actual=hung expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) m_tap[i] = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 valid in reset", RW'(out_valid), '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 valid after reset", RW'(out_valid), '0);
    check(result == '0, "R1 result after reset", result, '0);

    // R3, R9: single products under every signedness mix, random and extreme
    for (int k = 0; k < 24; k++)
      drive(2'd0, 0, 0, k[0], k[1], 0, rnd_a(), {$urandom, $urandom, $urandom}, "R3/R9 single");
    drive(2'd0, 0, 0, 0, 0, 0, '1, '1, "R9 unsigned max square");
    drive(2'd0, 0, 0, 1, 1, 0, {4{18'h20000}}, {4{18'h20000}}, "R9 signed min square");
    drive(2'd0, 0, 0, 1, 0, 0, '1, '1, "R9 signed times unsigned");
    drive(2'd0, 0, 0, 0, 1, 0, '1, '1, "R9 unsigned times signed");
    idle(2);

    // R4, R5, R11: accumulate with alternating sub, with gaps
    drive(2'd1, 0, 1, 1, 1, 0, rnd_a(), {$urandom, $urandom, $urandom}, "R5 clear load");
    for (int k = 0; k < 12; k++) begin
      drive(2'd1, k[0], 0, 1, 1, 0, rnd_a(), {$urandom, $urandom, $urandom}, "R4/R11 accumulate");
      if (k % 4 == 3) idle(1);
    end
    drive(2'd1, 1, 1, 1, 1, 0, rnd_a(), {$urandom, $urandom, $urandom}, "R5 clear subtract");

    // R6: other modes and idle cycles with clr must leave the accumulator alone
    drive(2'd2, 0, 0, 1, 0, 0, rnd_a(), {$urandom, $urandom, $urandom}, "R7 sum");
    drive(2'd3, 1, 1, 0, 1, 0, rnd_a(), {$urandom, $urandom, $urandom}, "R8 diff");
    drive(2'd0, 0, 1, 1, 1, 0, rnd_a(), {$urandom, $urandom, $urandom}, "R3 single");
    idle(3);
    drive(2'd1, 0, 0, 1, 1, 0, rnd_a(), {$urandom, $urandom, $urandom}, "R6 acc kept");

    // R7, R8, R11: pair and quad sums with per-sample sub and signs
    for (int k = 0; k < 16; k++)
      drive(2'd2, k[0], 0, k[1], k[2], 0, rnd_a(), {$urandom, $urandom, $urandom}, "R7/R11 two-product");
    for (int k = 0; k < 16; k++)
      drive(2'd3, k[0], 0, k[1], k[2], 0, rnd_a(), {$urandom, $urandom, $urandom}, "R8/R11 four-product");
    drive(2'd3, 0, 0, 0, 0, 0, '1, '1, "R8 unsigned max quad");
    drive(2'd3, 1, 0, 1, 1, 0, {4{18'h20000}}, {4{18'h1FFFF}}, "R8 signed extremes diff");
    idle(2);

    // R10: shift line, with idle cycles that must not advance it
    for (int k = 0; k < 10; k++) begin
      drive(2'd3, 0, 0, 1, 1, 1, rnd_a(), {$urandom, $urandom, $urandom}, "R10 shift line");
      if (k == 4) idle(2);
    end
    drive(2'd2, 1, 0, 1, 1, 1, rnd_a(), {$urandom, $urandom, $urandom}, "R10 shift two-product");
    drive(2'd3, 0, 0, 1, 1, 0, rnd_a(), {$urandom, $urandom, $urandom}, "R10 shift off reload");

    // R12: long run of maximal unsigned adds wraps the accumulator
    drive(2'd1, 0, 1, 0, 0, 0, '1, '1, "R12 wrap start");
    for (int k = 0; k < 600; k++)
      drive(2'd1, 0, 0, 0, 0, 0, '1, '1, "R12 accumulator wrap");

    idle(LAT + 4);
    check(q_exp.size() == 0, "R2 all results delivered", RW'(q_exp.size()), '0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule